// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is the peripheral side of a one-way SPI link from a host microcontroller. The host frames each command by pulling the active-low chip select low. It then clocks out one 16-bit word in SPI mode 0 and releases chip select. The block brings the serial clock, data and chip select into its own system clock domain through synchronisers. It shifts the word in, most significant bit first. When chip select is released after exactly 16 bits, the word is split into a 4-bit opcode and a 12-bit argument. These are presented together with a one-cycle valid strobe.

One opcode has a fixed meaning here: it writes the low byte of the argument into an 8-bit mode register. That register holds its value until the next such write. The meaning of every other opcode is left to logic downstream, which sees the strobe. A frame with any bit count other than 16 is dropped without a strobe.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset, cmd, data and conf_reg are zero and cmd_valid is low.
- R2: The first bit on the wire after chip select falls is cmd[3]. The fourth is cmd[0]. The next twelve bits are data[11] down to data[0].
- R3: A frame of exactly 16 bits produces exactly one cmd_valid pulse, one system clock wide, within 8 system clocks after cs_n rises.
- R4: A frame of fewer than 16 bits produces no cmd_valid pulse and leaves cmd, data and conf_reg unchanged.
- R5: A frame of more than 16 bits produces no cmd_valid pulse and leaves cmd, data and conf_reg unchanged.
- R6: A valid frame with opcode 4'h1 loads data[7:0] into conf_reg. Bits data[11:8] have no effect on conf_reg.
- R7: A valid frame with any opcode other than 4'h1 still strobes cmd_valid but leaves conf_reg unchanged.
- R8: SCK edges while cs_n is high are ignored. Each assertion of cs_n starts a fresh bit count, so an aborted frame does not corrupt the next one.
- R9: MOSI is sampled on the rising edge of SCK, which idles low. A change of MOSI while SCK is high does not alter the received bit.
- R10: cmd and data hold the value of the last valid frame between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host, idles low |
| mosi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low frame select |
| cmd | output | 4 | Opcode of the last valid word |
| data | output | 12 | Argument of the last valid word |
| cmd_valid | output | 1 | One-cycle strobe for a new word |
| conf_reg | output | 8 | Mode register |

## Verification
A wrong bit count or a shift register that is off by one shows up in two ways. Either the decoded opcode and argument come out rotated, or the strobe appears for a 15- or 17-bit frame. Both are visible within a few clocks of the chip select release. A lost or late edge detector leaves the strobe missing or stretched over more than one cycle. The mode register is checked after every frame, so a wrongly decoded opcode shows as a conf_reg change on the very frame that should not have touched it.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int DEF_CMD_W   = 4;
  localparam int DEF_DATA_W  = 12;
  localparam int DEF_CONF_W  = 8;
  localparam int DEF_STAGES  = 2;

  typedef enum logic {
    FR_IDLE  = 1'b0,
    FR_SHIFT = 1'b1
  } frame_state_t;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= RST_VAL;
          else     stage_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= RST_VAL;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              csn_s,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  frame_state_t      state_q;
  logic              sck_q;
  logic              csn_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q;

  logic sck_rise;
  logic cs_fall;
  logic cs_rise;

  assign sck_rise = sck_s & ~sck_q;
  assign cs_fall  = ~csn_s & csn_q;
  assign cs_rise  = csn_s & ~csn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      csn_q <= 1'b1;
    end else begin
      sck_q <= sck_s;
      csn_q <= csn_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      word_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        FR_IDLE: begin
          if (cs_fall) begin
            state_q <= FR_SHIFT;
            cnt_q   <= '0;
          end
        end
        FR_SHIFT: begin
          if (cs_rise) begin
            state_q <= FR_IDLE;
            if (cnt_q == CNT_W'(WORD_W)) begin
              word_o <= shift_q;
              done_o <= 1'b1;
            end
          end else if (sck_rise) begin
            shift_q <= {shift_q[WORD_W-2:0], mosi_s};
            if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= FR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode #(
  parameter int CMD_W  = 4,
  parameter int DATA_W = 12,
  parameter int CONF_W = 8,
  parameter logic [CMD_W-1:0] CONF_OPCODE = 4'h1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CMD_W+DATA_W-1:0] word_i,
  input  logic                    done_i,
  output logic [CMD_W-1:0]        cmd,
  output logic [DATA_W-1:0]       data,
  output logic                    cmd_valid,
  output logic [CONF_W-1:0]       conf_reg
);
  logic [CMD_W-1:0]  op_w;
  logic [DATA_W-1:0] arg_w;

  assign op_w  = word_i[CMD_W+DATA_W-1 -: CMD_W];
  assign arg_w = word_i[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd       <= '0;
      data      <= '0;
      cmd_valid <= 1'b0;
      conf_reg  <= '0;
    end else begin
      cmd_valid <= done_i;
      if (done_i) begin
        cmd  <= op_w;
        data <= arg_w;
        if (op_w == CONF_OPCODE) conf_reg <= arg_w[CONF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_pkg::*;
#(
  parameter int CMD_W   = DEF_CMD_W,
  parameter int DATA_W  = DEF_DATA_W,
  parameter int CONF_W  = DEF_CONF_W,
  parameter int STAGES  = DEF_STAGES,
  parameter logic [CMD_W-1:0] CONF_OPCODE = 4'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              mosi,
  input  logic              cs_n,
  output logic [CMD_W-1:0]  cmd,
  output logic [DATA_W-1:0] data,
  output logic              cmd_valid,
  output logic [CONF_W-1:0] conf_reg
);
  localparam int WORD_W = CMD_W + DATA_W;

  logic [2:0]        pins_s;
  logic [WORD_W-1:0] frame_word;
  logic              frame_done;

  spi_cmd_sync #(
    .WIDTH   (3),
    .STAGES  (STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({cs_n, sck, mosi}),
    .dout (pins_s)
  );

  spi_cmd_shifter #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk    (clk),
    .rst    (rst),
    .sck_s  (pins_s[1]),
    .mosi_s (pins_s[0]),
    .csn_s  (pins_s[2]),
    .word_o (frame_word),
    .done_o (frame_done)
  );

  spi_cmd_decode #(
    .CMD_W       (CMD_W),
    .DATA_W      (DATA_W),
    .CONF_W      (CONF_W),
    .CONF_OPCODE (CONF_OPCODE)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .word_i    (frame_word),
    .done_i    (frame_done),
    .cmd       (cmd),
    .data      (data),
    .cmd_valid (cmd_valid),
    .conf_reg  (conf_reg)
  );
endmodule

// File: rtl/spi_cmd_rx_chk.sv
module spi_cmd_rx_chk #(
  parameter int CMD_W  = 4,
  parameter int DATA_W = 12,
  parameter int CONF_W = 8,
  parameter logic [CMD_W-1:0] CONF_OPCODE = 4'h1
) (
  input logic              clk,
  input logic              rst,
  input logic [CMD_W-1:0]  cmd,
  input logic [DATA_W-1:0] data,
  input logic              cmd_valid,
  input logic [CONF_W-1:0] conf_reg,
  input logic              frame_done
);
  // R1: reset clears the outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (conf_reg == '0 && !cmd_valid && cmd == '0 && data == '0));

  // R3: strobe is one cycle wide
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R3: strobe only follows a completed frame
  p_strobe_source_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(frame_done));

  // R6: mode register changes only on a config opcode, with the low argument byte
  p_conf_write_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(conf_reg) |-> (cmd_valid && cmd == CONF_OPCODE
                            && conf_reg == data[CONF_W-1:0]));

  // R10: decoded fields hold between strobes
  p_hold_fields_r10: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> ($stable(cmd) && $stable(data)));
endmodule

bind spi_cmd_rx spi_cmd_rx_chk #(
  .CMD_W       (CMD_W),
  .DATA_W      (DATA_W),
  .CONF_W      (CONF_W),
  .CONF_OPCODE (CONF_OPCODE)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd        (cmd),
  .data       (data),
  .cmd_valid  (cmd_valid),
  .conf_reg   (conf_reg),
  .frame_done (frame_done)
);

// File: tb/test_spi_cmd_rx.sv
`timescale 1ns/1ps
module test_spi_cmd_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic cs_n = 1'b1;
  logic [3:0]  cmd;
  logic [11:0] data;
  logic        cmd_valid;
  logic [7:0]  conf_reg;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int run_len = 0;
  int max_run = 0;
  logic [3:0]  cap_cmd  = '0;
  logic [11:0] cap_data = '0;
  logic [7:0]  exp_conf = '0;
  bit done = 1'b0;

  localparam int HALF = 4;

  always #10 clk = ~clk;

  spi_cmd_rx i_spi_cmd_rx (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .cmd(cmd), .data(data), .cmd_valid(cmd_valid), .conf_reg(conf_reg)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      pulses++;
      run_len++;
      if (run_len > max_run) max_run = run_len;
      cap_cmd  = cmd;
      cap_data = data;
    end else begin
      run_len = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shift n bits, MSB of the n-bit value first; glitch flips MOSI mid-high
  task automatic send_bits(input logic [31:0] val, input int n, input bit glitch);
    cs_n = 1'b0;
    clks(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = val[i];
      clks(HALF);
      sck = 1'b1;
      clks(2);
      if (glitch) mosi = ~val[i];
      clks(HALF - 2);
      sck = 1'b0;
    end
    clks(HALF);
    cs_n = 1'b1;
    clks(12);
  endtask

  task automatic t_word(input logic [15:0] w, input bit glitch, input string tag);
    int p0;
    p0 = pulses;
    max_run = 0;
    send_bits({16'h0, w}, 16, glitch);
    if (w[15:12] == 4'h1) exp_conf = w[7:0];
    check({tag, " R3 one pulse"}, pulses - p0, 1);
    check({tag, " R3 width"}, max_run, 1);
    check({tag, " R2 cmd"}, cap_cmd, w[15:12]);
    check({tag, " R2 data"}, cap_data, w[11:0]);
    check({tag, " R6/R7 conf"}, conf_reg, exp_conf);
    check({tag, " R10 cmd hold"}, cmd, w[15:12]);
    check({tag, " R10 data hold"}, data, w[11:0]);
  endtask

  task automatic t_bad(input int n, input string tag);
    int p0;
    logic [3:0]  c0;
    logic [11:0] d0;
    p0 = pulses;
    c0 = cmd;
    d0 = data;
    send_bits(32'h1ABCD, n, 1'b0);
    check({tag, " no pulse"}, pulses - p0, 0);
    check({tag, " cmd kept"}, cmd, c0);
    check({tag, " data kept"}, data, d0);
    check({tag, " conf kept"}, conf_reg, exp_conf);
  endtask

  task automatic t_reset;
    check("R1 cmd", cmd, 0);
    check("R1 data", data, 0);
    check("R1 valid", cmd_valid, 0);
    check("R1 conf", conf_reg, 0);
  endtask

  task automatic t_idle_sck;
    int p0;
    p0 = pulses;
    for (int i = 0; i < 5; i++) begin
      mosi = i[0];
      sck = 1'b1; clks(HALF);
      sck = 1'b0; clks(HALF);
    end
    check("R8 idle sck no pulse", pulses - p0, 0);
    t_word(16'h1_5AA, 1'b0, "R8 after idle sck");
  endtask

  initial begin
    clks(5);
    rst = 1'b0;
    clks(3);
    t_reset();
    t_word(16'hA5C3, 1'b0, "R2 pattern A");
    t_word(16'h10F5, 1'b0, "R6 conf write");
    t_word(16'h1E3C, 1'b0, "R6 high bits ignored");
    t_word(16'h7FFF, 1'b0, "R7 other op");
    t_word(16'h0000, 1'b0, "R7 zeros");
    t_word(16'hFFFF, 1'b0, "R7 ones");
    t_bad(7,  "R4 short 7");
    t_bad(15, "R4 short 15");
    t_bad(17, "R5 long 17");
    t_word(16'h3456, 1'b0, "R8 after aborted frame");
    t_idle_sck();
    t_word(16'h1C69, 1'b1, "R9 mosi change while high");
    t_word(16'h9A5A, 1'b1, "R9 pattern B");
    done = 1'b1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
    end
  end

  initial begin
    wait (done || checks < 0);
    fork
      begin wait (done); end
    join
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100001) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule